// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a narrow host register bus reach a large internal register space through a small window. The host sees eight word offsets: a status word, a command word and four 16-bit holding words. To store a value into the internal space, software fills the holding words and then writes the command word with the target address and the read flag clear. To fetch a value, software writes the command word with the read flag set and later reads the result from the first holding word. Each internal access takes a fixed number of clock cycles. During that time a busy flag is set, and software polls it.

Each internal register is as wide as the four holding words together. A read returns a 16-bit slice of that register, and the lowest command address bit selects the slice. A 32-bit quantity therefore moves as two halves: software writes it once with holding word 0 as the low half and holding word 1 as the high half, and reads it back with two reads, one at the even address and one at the odd address.

The status word also carries two active-low release bits: one for the core and one for an external codec. Both clear to zero on reset. While the core release bit is low, the block stays inactive and its internal register file is held at zero.

Top module: `ind_reg_port`

## Requirements
- R1: After `rst_n` is deasserted, all of the following read as zero: the status word, the command word and every holding word. `xfer_busy`, `core_rst_n_o` and `codec_rst_n_o` are also low.
- R2: The host offsets are 0 for status, 1 for command, 2 to 5 for holding words 0 to 3, and 6 and 7 unused. A read presented on one clock edge drives `bus_rvalid` high for exactly the next cycle, with `bus_rdata` holding that word. On a cycle without a read, `bus_rvalid` is low.
- R3: In the status word, bit 1 is the core release bit and bit 2 is the codec release bit. Both are writable, and `core_rst_n_o` and `codec_rst_n_o` follow them. Bit 0 reads the busy flag and ignores writes. All other status bits read as zero.
- R4: When the core is released and the port is idle, a write to the command word starts an internal cycle. `xfer_busy` (and status bit 0) is high for exactly CYCLE_LEN cycles, 4 by default, starting the cycle after the write.
- R5: A command whose bit 7 is clear is a store. When the cycle completes, the internal register at index cmd[6:1] is loaded with {hold3, hold2, hold1, hold0}.
- R6: A command whose bit 7 is set is a fetch. When the cycle completes, holding word 0 is loaded with bits 15:0 of internal register cmd[6:1] if cmd[0] is 0, or with bits 31:16 if cmd[0] is 1. Holding words 1 to 3 are unchanged.
- R7: A command write while busy is ignored. The command word keeps its value, and the running cycle finishes on time with its original command.
- R8: A holding-word write while busy is ignored.
- R9: While the core release bit is 0, command writes are ignored and any running cycle is aborted, so busy falls on the next edge. The whole internal register file is also cleared to zero.
- R10: Offsets 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 3 | Word offset within the window |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| xfer_busy | output | 1 | Internal cycle in progress |
| core_rst_n_o | output | 1 | Core release bit (active-low reset) |
| codec_rst_n_o | output | 1 | Codec release bit (active-low reset) |

## Verification
The assertions assume that the host inputs are known at every rising edge and that `bus_reg` and `bus_wdata` matter only when `bus_sel` is high. The bus-cycle assertions treat a read and a write as mutually exclusive within one cycle, because `bus_we` decides which of the two happens. The bench drives every input on the falling edge and issues one host operation at a time, separated by idle cycles. Its busy-window and abort cases land command, holding and status writes at known offsets inside the running cycle, so that the ignore and abort paths are exercised deliberately rather than by chance.

// File: rtl/iport_pkg.sv
// Package: shared offsets and status bit positions for the indirect port.
// Assumes a fixed 3-bit host word offset.
package iport_pkg;
    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] OFS_STATUS = 3'd0;
    localparam logic [IDX_W-1:0] OFS_CMD    = 3'd1;
    localparam logic [IDX_W-1:0] OFS_HOLD   = 3'd2;
    localparam int ST_BUSY  = 0;
    localparam int ST_CORE  = 1;
    localparam int ST_CODEC = 2;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;
endpackage

// File: rtl/iport_host_regs.sv
// Module: host-visible registers (status, command, holding words) and the
// registered read path. Assumes DATA_W >= CMD_W and HOLD_N + 2 <= 8 offsets.
module iport_host_regs
    import iport_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOLD_N = 4,
    parameter int CMD_W  = 8,
    localparam int HOLD_W = HOLD_N * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_value,
    output logic              start,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [HOLD_W-1:0] hold_flat,
    output logic              core_n,
    output logic              codec_n,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    logic              host_wr;
    logic              host_rd;
    logic [DATA_W-1:0] hold_q [HOLD_N];
    logic [DATA_W-1:0] rd_mux;

    assign host_wr = bus_sel && bus_we;
    assign host_rd = bus_sel && !bus_we;
    assign start   = host_wr && (bus_reg == OFS_CMD) && !busy && core_n;

    // Purpose: hold the two release bits written through the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_n  <= 1'b0;
            codec_n <= 1'b0;
        end else if (host_wr && bus_reg == OFS_STATUS) begin
            core_n  <= bus_wdata[ST_CORE];
            codec_n <= bus_wdata[ST_CODEC];
        end
    end

    // Purpose: capture the command word when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= bus_wdata[CMD_W-1:0];
        end
    end

    for (genvar g = 0; g < HOLD_N; g++) begin : g_hold
        // Purpose: one holding word; word 0 also takes fetch results.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
            end else if (g == 0 && rd_load) begin
                hold_q[g] <= rd_value;
            end else if (host_wr && !busy && int'(bus_reg) == int'(OFS_HOLD) + g) begin
                hold_q[g] <= bus_wdata;
            end
        end
        assign hold_flat[g*DATA_W +: DATA_W] = hold_q[g];
    end

    // Purpose: select the word addressed by a host read.
    always_comb begin
        rd_mux = '0;
        if (bus_reg == OFS_STATUS) begin
            rd_mux[ST_BUSY]  = busy;
            rd_mux[ST_CORE]  = core_n;
            rd_mux[ST_CODEC] = codec_n;
        end else if (bus_reg == OFS_CMD) begin
            rd_mux[CMD_W-1:0] = cmd_q;
        end else begin
            for (int k = 0; k < HOLD_N; k++) begin
                if (int'(bus_reg) == int'(OFS_HOLD) + k) begin
                    rd_mux = hold_q[k];
                end
            end
        end
    end

    // Purpose: register read data so it appears one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= host_rd;
            if (host_rd) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/iport_seq.sv
// Module: cycle sequencer; holds busy for CYCLE_LEN cycles and pulses fire
// in the last one. Assumes CYCLE_LEN >= 1 and start only when idle.
module iport_seq
    import iport_pkg::*;
#(
    parameter int CYCLE_LEN = 4,
    localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Purpose: run the busy window, aborting when the core is held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        cnt   <= CNT_W'(CYCLE_LEN - 1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state == SEQ_RUN);
    assign fire = busy && (cnt == '0);
endmodule

// File: rtl/iport_regfile.sv
// Module: behavioural internal register file, one wide entry per even/odd
// address pair. Assumes HOLD_N >= 2 so both read halves exist.
module iport_regfile #(
    parameter int DATA_W  = 16,
    parameter int HOLD_N  = 4,
    parameter int IADDR_W = 7,
    localparam int HOLD_W  = HOLD_N * DATA_W,
    localparam int ENTRIES = 2 ** (IADDR_W - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_n,
    input  logic               wr_en,
    input  logic [IADDR_W-1:0] addr,
    input  logic [HOLD_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_half
);
    logic [HOLD_W-1:0] mem [ENTRIES];
    logic [HOLD_W-1:0] entry;

    // Purpose: store writes; clear the whole file while the core is held.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr[IADDR_W-1:1]] <= wdata;
        end
    end

    // Purpose: pick the 16-bit slice selected by the low address bit.
    always_comb begin
        entry   = mem[addr[IADDR_W-1:1]];
        rd_half = addr[0] ? entry[2*DATA_W-1:DATA_W] : entry[DATA_W-1:0];
    end
endmodule

// File: rtl/ind_reg_port.sv
// Module: top of the indirect register access port. Connects the host
// registers, the sequencer and the internal file. Assumes CMD_W-1 address bits
// plus one read flag in the command word.
module ind_reg_port
    import iport_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HOLD_N    = 4,
    parameter int CMD_W     = 8,
    parameter int CYCLE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              xfer_busy,
    output logic              core_rst_n_o,
    output logic              codec_rst_n_o
);
    localparam int IADDR_W = CMD_W - 1;
    localparam int RD_FLAG = CMD_W - 1;
    localparam int HOLD_W  = HOLD_N * DATA_W;

    logic              start;
    logic              busy;
    logic              fire;
    logic [CMD_W-1:0]  cmd_q;
    logic [HOLD_W-1:0] hold_flat;
    logic [DATA_W-1:0] rd_half;
    logic              core_n;
    logic              codec_n;

    iport_host_regs #(.DATA_W(DATA_W), .HOLD_N(HOLD_N), .CMD_W(CMD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_reg    (bus_reg),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .rd_load    (fire && cmd_q[RD_FLAG]),
        .rd_value   (rd_half),
        .start      (start),
        .cmd_q      (cmd_q),
        .hold_flat  (hold_flat),
        .core_n     (core_n),
        .codec_n    (codec_n),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    iport_seq #(.CYCLE_LEN(CYCLE_LEN)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .core_n (core_n),
        .start  (start),
        .busy   (busy),
        .fire   (fire)
    );

    iport_regfile #(.DATA_W(DATA_W), .HOLD_N(HOLD_N), .IADDR_W(IADDR_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_n  (core_n),
        .wr_en   (fire && !cmd_q[RD_FLAG]),
        .addr    (cmd_q[IADDR_W-1:0]),
        .wdata   (hold_flat),
        .rd_half (rd_half)
    );

    assign xfer_busy     = busy;
    assign core_rst_n_o  = core_n;
    assign codec_rst_n_o = codec_n;
endmodule

// File: rtl/ind_reg_port_chk.sv
// Module: property checker bound to the top; watches host ports, busy and
// the captured command. Assumes known inputs at every edge.
module ind_reg_port_chk
    import iport_pkg::*;
#(
    parameter int CYCLE_LEN = 4,
    parameter int CMD_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [2:0]       bus_reg,
    input logic             bus_rvalid,
    input logic             xfer_busy,
    input logic             core_rst_n_o,
    input logic             codec_rst_n_o,
    input logic [CMD_W-1:0] cmd_q
);
    int run_len;

    // Purpose: count consecutive busy cycles for the window checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (xfer_busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> run_len < CYCLE_LEN);
    // R4
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(xfer_busy) && $past(core_rst_n_o)) |-> run_len == CYCLE_LEN);
    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(bus_sel && bus_we && bus_reg == OFS_CMD));
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && bus_sel && bus_we && bus_reg == OFS_CMD) |=> $stable(cmd_q));
    // R2
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);
    // R2
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !bus_rvalid);
    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n_o |=> !xfer_busy);
    // R3
    codec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_reg == OFS_STATUS) |=> $stable(codec_rst_n_o));
endmodule

bind ind_reg_port ind_reg_port_chk #(.CYCLE_LEN(CYCLE_LEN), .CMD_W(CMD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_reg       (bus_reg),
    .bus_rvalid    (bus_rvalid),
    .xfer_busy     (xfer_busy),
    .core_rst_n_o  (core_rst_n_o),
    .codec_rst_n_o (codec_rst_n_o),
    .cmd_q         (cmd_q)
);

// File: tb/ind_reg_port_tb.sv
module ind_reg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_reg = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        xfer_busy;
    logic        core_rst_n_o;
    logic        codec_rst_n_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string cur_tag = "R2";

    // behavioural reference state
    bit          m_core = 0, m_codec = 0, m_busy = 0, m_rvalid = 0;
    int          m_cnt = 0;
    logic [7:0]  m_cmd = '0;
    logic [15:0] m_hold [4] = '{default: '0};
    logic [15:0] m_rdata = '0;
    logic [63:0] m_mem [64];

    ind_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .xfer_busy(xfer_busy),
        .core_rst_n_o(core_rst_n_o), .codec_rst_n_o(codec_rst_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [2:0] r);
        case (r)
            3'd0: return {13'b0, m_codec, m_core, m_busy};
            3'd1: return {8'b0, m_cmd};
            3'd2, 3'd3, 3'd4, 3'd5: return m_hold[r - 3'd2];
            default: return 16'h0;
        endcase
    endfunction

    // reference model step on every rising edge
    always @(posedge clk) begin
        bit core_pre, busy_pre;
        started = 1'b1;
        if (!rst_n) begin
            m_core = 0; m_codec = 0; m_busy = 0; m_cnt = 0; m_rvalid = 0;
            m_cmd = '0; m_rdata = '0;
            for (int i = 0; i < 4; i++) m_hold[i] = '0;
            for (int i = 0; i < 64; i++) m_mem[i] = '0;
        end else begin
            core_pre = m_core;
            busy_pre = m_busy;
            m_rvalid = bus_sel && !bus_we;
            if (m_rvalid) m_rdata = m_read(bus_reg);
            if (!core_pre) begin
                m_busy = 0; m_cnt = 0;
                for (int i = 0; i < 64; i++) m_mem[i] = '0;
            end else if (busy_pre) begin
                if (m_cnt == 0) begin
                    if (m_cmd[7]) m_hold[0] = m_cmd[0] ? m_mem[m_cmd[6:1]][31:16]
                                                       : m_mem[m_cmd[6:1]][15:0];
                    else m_mem[m_cmd[6:1]] = {m_hold[3], m_hold[2], m_hold[1], m_hold[0]};
                    m_busy = 0;
                end else begin
                    m_cnt--;
                end
            end
            if (bus_sel && bus_we) begin
                case (bus_reg)
                    3'd0: begin m_core = bus_wdata[1]; m_codec = bus_wdata[2]; end
                    3'd1: if (!busy_pre && core_pre) begin
                        m_cmd = bus_wdata[7:0]; m_busy = 1; m_cnt = CYC - 1;
                    end
                    3'd2, 3'd3, 3'd4, 3'd5: if (!busy_pre) m_hold[bus_reg - 3'd2] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R4 busy flag", {15'b0, xfer_busy}, {15'b0, m_busy});
            chk("R2 read valid", {15'b0, bus_rvalid}, {15'b0, m_rvalid});
            chk("R3 release outputs", {14'b0, codec_rst_n_o, core_rst_n_o},
                {14'b0, m_codec, m_core});
            if (m_rvalid) chk({cur_tag, " read data"}, bus_rdata, m_rdata);
        end
    end

    task automatic bus_write(input logic [2:0] r, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [2:0] r, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_reg = r;
        @(negedge clk);
        bus_sel = 0;
        v = bus_rdata;
    endtask

    task automatic settle();
        repeat (CYC + 3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cur_tag = "R1";
        bus_read(3'd0, v); chk("R1 status after reset", v, 16'h0);
        bus_read(3'd1, v); chk("R1 command after reset", v, 16'h0);
        for (int i = 0; i < 4; i++) begin
            bus_read(3'(i + 2), v); chk("R1 holding after reset", v, 16'h0);
        end
        chk("R1 release outputs low", {14'b0, codec_rst_n_o, core_rst_n_o}, 16'h0);

        // R9 command ignored while core held
        cur_tag = "R9";
        bus_write(3'd1, 16'h0004);
        @(negedge clk); chk("R9 no busy while held", {15'b0, xfer_busy}, 16'h0);
        bus_read(3'd1, v); chk("R9 command ignored while held", v, 16'h0);

        // R3 status release bits
        cur_tag = "R3";
        bus_write(3'd0, 16'h0007);
        bus_read(3'd0, v); chk("R3 status bits, busy read-only", v, 16'h0006);
        bus_write(3'd0, 16'h0002);
        chk("R3 codec held", {15'b0, codec_rst_n_o}, 16'h0);
        bus_write(3'd0, 16'h0006);
        chk("R3 codec released", {15'b0, codec_rst_n_o}, 16'h1);

        // R5 store of a 32-bit value, R4 busy window
        cur_tag = "R5";
        bus_write(3'd2, 16'h1234); bus_write(3'd3, 16'hABCD);
        bus_write(3'd4, 16'h0000); bus_write(3'd5, 16'h0000);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_reg = 3'd1; bus_wdata = 16'h0010;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        run = 0;
        while (xfer_busy && run < 50) begin run++; @(negedge clk); end
        chk("R4 busy length", 16'(run), 16'(CYC));

        // R6 fetch both halves
        cur_tag = "R6";
        bus_write(3'd2, 16'h0000);
        bus_write(3'd1, 16'h0090); settle();
        bus_read(3'd2, v); chk("R6 low half fetch", v, 16'h1234);
        bus_write(3'd1, 16'h0091); settle();
        bus_read(3'd2, v); chk("R6 high half fetch", v, 16'hABCD);
        bus_read(3'd3, v); chk("R6 hold1 unchanged by fetch", v, 16'hABCD);

        // R7 command write during busy ignored
        cur_tag = "R7";
        bus_write(3'd1, 16'h0090);
        bus_write(3'd1, 16'h0020);
        settle();
        bus_read(3'd1, v); chk("R7 command kept", v, 16'h0090);
        bus_read(3'd2, v); chk("R7 original fetch completed", v, 16'h1234);

        // R8 holding write during busy ignored
        cur_tag = "R8";
        bus_write(3'd2, 16'h1111); bus_write(3'd3, 16'h2222);
        bus_write(3'd4, 16'h3333); bus_write(3'd5, 16'h4444);
        bus_write(3'd1, 16'h0030);
        bus_write(3'd3, 16'hBEEF);
        settle();
        bus_read(3'd3, v); chk("R8 hold1 write ignored", v, 16'h2222);
        bus_write(3'd1, 16'h00B1); settle();
        bus_read(3'd2, v); chk("R8 stored value intact", v, 16'h2222);

        // R10 unused offsets
        cur_tag = "R10";
        bus_write(3'd6, 16'hFFFF); bus_write(3'd7, 16'hFFFF);
        bus_read(3'd6, v); chk("R10 offset 6 reads zero", v, 16'h0);
        bus_read(3'd7, v); chk("R10 offset 7 reads zero", v, 16'h0);
        bus_read(3'd4, v); chk("R10 hold2 untouched", v, 16'h3333);

        // R9 abort and clear
        cur_tag = "R9";
        bus_write(3'd1, 16'h0040);
        bus_write(3'd0, 16'h0000);
        @(negedge clk); chk("R9 busy aborted", {15'b0, xfer_busy}, 16'h0);
        bus_write(3'd0, 16'h0006);
        bus_write(3'd1, 16'h0090); settle();
        bus_read(3'd2, v); chk("R9 file cleared", v, 16'h0);

        // R2 no valid without a read
        cur_tag = "R2";
        bus_write(3'd2, 16'h5A5A);
        chk("R2 no valid after write", {15'b0, bus_rvalid}, 16'h0);
        bus_read(3'd2, v); chk("R2 hold0 read", v, 16'h5A5A);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule